// File: doc/BRIEF.md
# Packed SIMD Absolute-Difference Unit

This block is a one-stage execution slice for a 128-bit vector instruction that returns, for every lane, the distance between the two source lanes. It takes a 32-bit instruction word, two 128-bit operands and an input strobe. It then decides whether the word is one of the eight absolute-difference variants and picks the lane width (8, 16, 32 or 64 bits) and whether lanes compare as signed or unsigned. One clock edge later it presents the packed result, a valid flag and the destination register index.

Every lane is computed on its own. The result of a lane is its larger operand minus its smaller one, kept to the lane width. A word that carries the strobe but does not match the instruction group raises a separate illegal flag instead of producing a result. Register-file access, exception delivery and hazard handling sit in the surrounding pipeline.

Top module: `absdiff_unit`

## Requirements
- R1: A word is accepted only when bits [31:28] are 0111, bits [27:20] are 00000110 and bits [19:18] are 00. Any other word strobed in raises `out_illegal` one cycle later with `out_valid` low.
- R2: Variant field bits [19:15] values 00000, 00001, 00010 and 00011 select signed lanes of 8, 16, 32 and 64 bits. These lanes compare as two's-complement values.
- R3: Variant values 00100, 00101, 00110 and 00111 select unsigned lanes of 8, 16, 32 and 64 bits. These lanes compare as unsigned magnitudes.
- R4: Each lane result is max(a,b) minus min(a,b), taken modulo 2^width. For example, the signed bytes 127 and -128 give 0xFF, and equal operands give 0.
- R5: Lanes are independent, and no borrow or comparison crosses a lane boundary. Lane k occupies bits [k*W +: W] of each operand and of the result.
- R6: When `out_valid` is high, `out_dest` carries instruction bits [4:0] of the word that produced it. Source fields sit in bits [9:5] and [14:10] and do not affect the result.
- R7: A legal strobed word makes `out_valid` high exactly one cycle later, with `out_illegal` low.
- R8: A cycle without a strobe leaves `out_valid` and `out_illegal` low in the following cycle. `out_data` and `out_dest` are zero whenever `out_valid` is low.
- R9: Synchronous active-high reset clears all outputs at the next edge, and it takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| instr | input | 32 | Instruction word |
| opnd_a | input | 128 | First source vector |
| opnd_b | input | 128 | Second source vector |
| out_valid | output | 1 | Registered result valid |
| out_illegal | output | 1 | Registered flag for a strobed word outside the group |
| out_data | output | 128 | Registered packed lane results |
| out_dest | output | 5 | Registered destination register index |

## Verification
The byte variants are swept exhaustively. Every one of the 65,536 byte pairs is placed across the sixteen lanes under both the signed and the unsigned encoding, which separates signed from unsigned comparison wherever exactly one operand has its top bit set. The halfword, word and doubleword variants run on pseudo-random operands and on extreme values (most negative against most positive, all-ones against zero). These cases reveal a wrong lane partition, a borrow leaking across lanes, and a wrong modulo wrap. Words that differ from a legal one in a single group bit or in the variant field, together with idle cycles and reset applied during a strobe, cover the decode, the flags and the cleared outputs.

// File: rtl/absdiff_pkg.sv
package absdiff_pkg;

    localparam int VLEN     = 128;
    localparam int INSTR_W  = 32;
    localparam int REG_IDX_W = 5;
    localparam int NUM_WIDTHS = 4;
    localparam int MIN_LANE_W = 8;

    localparam logic [3:0] GRP_MAJOR = 4'b0111;
    localparam logic [7:0] GRP_MINOR = 8'b0000_0110;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_sel_e;

    typedef struct packed {
        logic                 legal;
        logic                 is_signed;
        lane_sel_e            width;
        logic [REG_IDX_W-1:0] dest;
    } dec_t;

    function automatic int lane_bits(input int sel);
        return MIN_LANE_W << sel;
    endfunction

endpackage

// File: rtl/absdiff_decode.sv
module absdiff_decode
    import absdiff_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic grp_hit;
    logic var_hit;

    always_comb begin
        grp_hit       = (instr[31:28] == GRP_MAJOR) && (instr[27:20] == GRP_MINOR);
        var_hit       = (instr[19:18] == 2'b00);
        dec.legal     = grp_hit && var_hit;
        dec.is_signed = ~instr[17];
        dec.width     = lane_sel_e'(instr[16:15]);
        dec.dest      = instr[REG_IDX_W-1:0];
    end
endmodule

// File: rtl/absdiff_lanes.sv
module absdiff_lanes #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic             is_signed,
    output logic [VEC_W-1:0] result
);
    localparam int NLANES = VEC_W / LANE_W;
    localparam int MSB    = LANE_W - 1;

    for (genvar li = 0; li < NLANES; li++) begin : g_lane
        logic [LANE_W-1:0] xa, xb;
        logic [LANE_W-1:0] ka, kb;
        logic              a_gt;

        assign xa = a[li*LANE_W +: LANE_W];
        assign xb = b[li*LANE_W +: LANE_W];
        // Flipping the sign bit maps two's-complement order onto unsigned order.
        assign ka = {xa[MSB] ^ is_signed, xa[MSB-1:0]};
        assign kb = {xb[MSB] ^ is_signed, xb[MSB-1:0]};
        assign a_gt = (ka > kb);
        assign result[li*LANE_W +: LANE_W] = a_gt ? (xa - xb) : (xb - xa);
    end
endmodule

// File: rtl/absdiff_unit.sv
module absdiff_unit
    import absdiff_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [VLEN-1:0]      opnd_a,
    input  logic [VLEN-1:0]      opnd_b,
    output logic                 out_valid,
    output logic                 out_illegal,
    output logic [VLEN-1:0]      out_data,
    output logic [REG_IDX_W-1:0] out_dest
);
    dec_t            dec;
    logic [VLEN-1:0] lane_res [NUM_WIDTHS];
    logic [VLEN-1:0] picked;
    logic            accept;
    logic            reject;

    absdiff_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    for (genvar gi = 0; gi < NUM_WIDTHS; gi++) begin : g_width
        absdiff_lanes #(
            .VEC_W  (VLEN),
            .LANE_W (lane_bits(gi))
        ) u_lanes (
            .a         (opnd_a),
            .b         (opnd_b),
            .is_signed (dec.is_signed),
            .result    (lane_res[gi])
        );
    end

    always_comb begin
        picked = lane_res[dec.width];
        accept = in_valid && dec.legal;
        reject = in_valid && !dec.legal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_data    <= '0;
            out_dest    <= '0;
        end else begin
            out_valid   <= accept;
            out_illegal <= reject;
            out_data    <= accept ? picked : '0;
            out_dest    <= accept ? dec.dest : '0;
        end
    end
endmodule

// File: rtl/absdiff_unit_chk.sv
module absdiff_unit_chk
    import absdiff_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [INSTR_W-1:0]   instr,
    input logic [VLEN-1:0]      opnd_a,
    input logic [VLEN-1:0]      opnd_b,
    input logic                 out_valid,
    input logic                 out_illegal,
    input logic [VLEN-1:0]      out_data,
    input logic [REG_IDX_W-1:0] out_dest
);
    logic word_ok;
    assign word_ok = (instr[31:20] == 12'h706) && (instr[19:18] == 2'b00);

    p_flags_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));

    p_bad_word_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !word_ok) |=> (out_illegal && !out_valid));

    p_zero_distance_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && word_ok && (opnd_a == opnd_b)) |=> (out_data == '0));

    p_dest_forward_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && word_ok) |=> (out_dest == $past(instr[4:0])));

    p_valid_latency_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && word_ok) |=> (out_valid && !out_illegal));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal && out_data == '0));
endmodule

bind absdiff_unit absdiff_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .instr       (instr),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_data    (out_data),
    .out_dest    (out_dest)
);

// File: tb/absdiff_unit_bench.sv
module absdiff_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         out_valid;
    logic         out_illegal;
    logic [127:0] out_data;
    logic [4:0]   out_dest;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    absdiff_unit u_absdiff_unit (
        .clk (clk), .rst (rst), .in_valid (in_valid), .instr (instr),
        .opnd_a (opnd_a), .opnd_b (opnd_b), .out_valid (out_valid),
        .out_illegal (out_illegal), .out_data (out_data), .out_dest (out_dest)
    );

    function automatic logic [31:0] mk(input logic [4:0] vsel, input logic [4:0] d);
        return {4'b0111, 8'b0000_0110, vsel, 5'd9, 5'd17, d};
    endfunction

    function automatic logic [127:0] model(input int w, input bit sg,
                                           input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r = '0;
        logic [63:0] mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        logic [63:0] sbit = 64'd1 << (w - 1);
        for (int l = 0; l < 128 / w; l++) begin
            logic [63:0] la = 64'((a >> (l * w))) & mask;
            logic [63:0] lb = 64'((b >> (l * w))) & mask;
            logic [63:0] ca = sg ? (la ^ sbit) : la;
            logic [63:0] cb = sg ? (lb ^ sbit) : lb;
            logic [63:0] d  = (ca > cb) ? (la - lb) : (lb - la);
            r = r | (128'(d & mask) << (l * w));
        end
        return r;
    endfunction

    function automatic logic [63:0] xs(input logic [63:0] x);
        logic [63:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    task automatic expect_out(input string tag, input bit ev, input bit ei,
                              input logic [127:0] ed, input logic [4:0] edst);
        checks++;
        if (out_valid !== ev || out_illegal !== ei || out_data !== ed || out_dest !== edst) begin
            errors++;
            $display("FAIL %s: got v=%0b i=%0b d=%h dst=%0d, expected v=%0b i=%0b d=%h dst=%0d",
                     tag, out_valid, out_illegal, out_data, out_dest, ev, ei, ed, edst);
        end
    endtask

    // Drive one strobed word at a falling edge, then check at the next falling edge.
    task automatic run(input string tag, input logic [31:0] ins,
                       input logic [127:0] a, input logic [127:0] b);
        bit legal = (ins[31:20] == 12'h706) && (ins[19:18] == 2'b00);
        int w = 8 << ins[16:15];
        bit sg = !ins[17];
        in_valid = 1'b1; instr = ins; opnd_a = a; opnd_b = b;
        @(negedge clk);
        if (legal) expect_out(tag, 1'b1, 1'b0, model(w, sg, a, b), ins[4:0]);
        else       expect_out(tag, 1'b0, 1'b1, '0, 5'd0);
    endtask

    initial begin
        logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;
        repeat (3) @(negedge clk);
        expect_out("R9 reset state", 1'b0, 1'b0, '0, 5'd0);
        rst = 1'b0;

        // R2 R3 R4 R5: exhaustive byte-pair sweep, signed then unsigned
        for (int sgn = 0; sgn < 2; sgn++) begin
            for (int i = 0; i < 4096; i++) begin
                logic [127:0] a = '0, b = '0;
                for (int k = 0; k < 16; k++) begin
                    logic [15:0] p = 16'(i * 16 + k);
                    a[k*8 +: 8] = p[15:8];
                    b[k*8 +: 8] = p[7:0];
                end
                run(sgn == 0 ? "R2 R4 signed byte sweep" : "R3 R4 unsigned byte sweep",
                    mk(sgn == 0 ? 5'b00000 : 5'b00100, 5'(i)), a, b);
            end
        end

        // R2 R3 R5: wider lanes on pseudo-random operands
        for (int v = 0; v < 8; v++) begin
            if (v[1:0] == 2'b00) continue;
            for (int n = 0; n < 300; n++) begin
                logic [127:0] a, b;
                seed = xs(seed); a[63:0] = seed;
                seed = xs(seed); a[127:64] = seed;
                seed = xs(seed); b[63:0] = seed;
                seed = xs(seed); b[127:64] = seed;
                run(v < 4 ? "R2 R5 signed wide random" : "R3 R5 unsigned wide random",
                    mk(5'(v), 5'(n)), a, b);
            end
        end

        // R4: extremes and modulo wrap
        run("R4 signed byte 127 vs -128", mk(5'b00000, 5'd1), {16{8'h7F}}, {16{8'h80}});
        run("R4 signed dword extremes", mk(5'b00011, 5'd2),
            {2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'h8000_0000_0000_0000}});
        run("R4 unsigned dword ones vs zero", mk(5'b00111, 5'd3), '1, '0);
        run("R4 equal operands", mk(5'b00110, 5'd4), {4{32'hDEAD_BEEF}}, {4{32'hDEAD_BEEF}});
        run("R5 no borrow across halfwords", mk(5'b00101, 5'd5),
            {8{16'h0100}}, {8{16'h00FF}});
        run("R6 dest index 31", mk(5'b00001, 5'd31), {8{16'h1234}}, {8{16'h0034}});

        // R1: single-bit departures from the group and out-of-range variants
        run("R1 major bits", {4'b0110, 8'b0000_0110, 5'b00000, 15'd7}, '1, '0);
        run("R1 minor bits", {4'b0111, 8'b0000_0111, 5'b00000, 15'd7}, '1, '0);
        run("R1 variant 01000", mk(5'b01000, 5'd7), '1, '0);
        run("R1 variant 11111", mk(5'b11111, 5'd7), '1, '0);
        run("R7 legal after illegal", mk(5'b00010, 5'd8), {4{32'd5}}, {4{32'd9}});

        // R8: idle cycles
        in_valid = 1'b0; opnd_a = '1; instr = mk(5'b00000, 5'd3);
        @(negedge clk);
        expect_out("R8 idle after strobe", 1'b0, 1'b0, '0, 5'd0);
        @(negedge clk);
        expect_out("R8 idle held", 1'b0, 1'b0, '0, 5'd0);

        // R9: reset wins over a strobe
        in_valid = 1'b1; rst = 1'b1; instr = mk(5'b00100, 5'd12);
        opnd_a = '1; opnd_b = '0;
        @(negedge clk);
        expect_out("R9 reset over strobe", 1'b0, 1'b0, '0, 5'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule